// File: doc/BRIEF.md
# Single-Cycle 16-Bit Accumulator Processor Core

This block is a small processor core that runs one instruction per clock. It has separate ports for program memory and data memory. In each cycle it reads a 16-bit instruction word and a 16-bit data word. It presents a data address, a write word and a write strobe for that same cycle. At the next rising edge it updates its two working registers and the program counter. Program storage, data storage and any peripherals are outside the core.

Every instruction word is one of two kinds, and the top bit selects the kind:

- **Literal load** (top bit 0). A 15-bit constant goes into the address register.
- **Compute** (top bit 1). The word is split into four fields:
  - an operand select;
  - six ALU control bits;
  - a three-bit destination mask;
  - a three-bit jump condition.

  The jump condition tests the sign and zero status of the ALU result. A taken jump loads the program counter from the address register.

Top module: `acc_cpu16`

## Requirements
- R1: Reset is synchronous and active-low. After a rising edge with `rst_n` low, the program counter, the A register and the D register are all zero. This holds even when the instruction present during reset requests a jump.
- R2: When instruction bit 15 is 0, A takes instruction bits 14..0 with bit 15 cleared at the next edge. D is unchanged, the write strobe stays low, and the program counter increments.
- R3: When bit 15 is 1 and destination bit 5 is set, A takes the ALU result at the next edge.
- R4: In a compute instruction, bit 12 selects the second ALU operand: 0 selects A, 1 selects `dmem_rdata_i`. The first operand is always D.
- R5: Bits 11..6 are, in order from bit 11 down: zero-x, invert-x, zero-y, invert-y, function, invert-output.
  - The zero step applies before the invert step on each operand.
  - Function 1 selects x+y (modulo 2^16); function 0 selects x AND y.
  - Invert-output complements the final word.
- R6: In a compute instruction, destination bit 4 loads D from the ALU result. Bits 5, 4 and 3 may be set in any combination, and each target is updated independently.
- R7: `dmem_we_o` is high exactly when bit 15 and bit 3 are both 1. `dmem_wdata_o` then carries the ALU result in the same cycle.
- R8: `dmem_addr_o` always equals the low 15 bits of the current A register.
- R9: In a compute instruction, jump bits 2, 1 and 0 request a jump when the result is negative, zero or positive respectively. Negative means bit 15 of the result is set. Positive means the result is neither zero nor negative. Any matching requested condition takes the jump.
- R10: The program counter updates with this priority:
  1. reset clears it;
  2. otherwise a taken jump loads the low 15 bits of A;
  3. otherwise it adds one, wrapping from 0x7FFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | Instruction word fetched at `pc_o` |
| dmem_rdata_i | input | 16 | Data word read at `dmem_addr_o` |
| dmem_addr_o | output | 15 | Data-memory address (low bits of A) |
| dmem_wdata_o | output | 16 | Data word to store (ALU result) |
| dmem_we_o | output | 1 | Data-memory write strobe |
| pc_o | output | 15 | Address of the current instruction |

## Verification
The D register has no port of its own, and its value is the hardest state to observe. The stimulus makes it visible by issuing a compute instruction that passes D unchanged through the ALU to the memory destination. The write word then shows D on the data bus. The same approach covers:

- checking that D is cleared after reset;
- checking that D is left untouched by literal loads whose low bits mimic a destination mask.

Jump conditions are reached by loading a target into A with a literal and then computing a constant whose sign is chosen on purpose. Every one of the eight condition codes is paired with a negative, a zero and a positive result.

// File: rtl/acc_cpu16_pkg.sv
// Package: shared constants and types for the accumulator core.
// Assumes a fixed 16-bit instruction encoding; bit positions are part of
// the instruction format and therefore fixed, not parameters.
package acc_cpu16_pkg;
    localparam int WORD_W   = 16;
    localparam int LIT_W    = WORD_W - 1;
    localparam int KIND_BIT = 15;  // 1 = compute, 0 = literal
    localparam int OPSEL_BIT = 12; // second operand: 0 = A, 1 = memory
    localparam int CTRL_HI  = 11;
    localparam int CTRL_LO  = 6;
    localparam int DST_A_BIT = 5;
    localparam int DST_D_BIT = 4;
    localparam int DST_M_BIT = 3;
    localparam int JMP_W    = 3;

    // ALU control fields, most significant first as encoded
    typedef struct packed {
        logic zero_x;
        logic inv_x;
        logic zero_y;
        logic inv_y;
        logic add_sel;
        logic inv_out;
    } alu_ctrl_t;

    // Decoded control for one instruction
    typedef struct packed {
        logic             is_comp;
        logic             sel_mem;
        alu_ctrl_t        alu;
        logic             ld_a;
        logic             ld_d;
        logic             wr_m;
        logic [JMP_W-1:0] jmp;
    } dec_t;
endpackage

// File: rtl/acc_cpu16_alu.sv
// Module: six-control ALU with zero and negative flags.
// Assumes controls are applied in sequence: zero then invert per operand,
// add or AND, then optional output inversion. Purely combinational.
module acc_cpu16_alu
    import acc_cpu16_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  alu_ctrl_t    ctrl_i,
    output logic [W-1:0] res_o,
    output logic         zr_o,
    output logic         ng_o
);
    logic [W-1:0] x_z, x_m, y_z, y_m, core;

    // Operand conditioning, function select and output inversion
    always_comb begin
        x_z   = ctrl_i.zero_x ? '0 : x_i;
        x_m   = ctrl_i.inv_x ? ~x_z : x_z;
        y_z   = ctrl_i.zero_y ? '0 : y_i;
        y_m   = ctrl_i.inv_y ? ~y_z : y_z;
        core  = ctrl_i.add_sel ? (x_m + y_m) : (x_m & y_m);
        res_o = ctrl_i.inv_out ? ~core : core;
    end

    // Status flags of the final result
    always_comb begin
        zr_o = (res_o == '0);
        ng_o = res_o[W-1];
    end
endmodule

// File: rtl/acc_cpu16_decode.sv
// Module: instruction decoder.
// Assumes the 16-bit two-kind format; destination and jump fields are
// forced inactive for literal instructions, and A loads on every literal.
module acc_cpu16_decode
    import acc_cpu16_pkg::*;
(
    input  logic [WORD_W-1:0] instr_i,
    output dec_t              dec_o
);
    // Split the word into control fields qualified by the kind bit
    always_comb begin
        dec_o.is_comp = instr_i[KIND_BIT];
        dec_o.sel_mem = instr_i[KIND_BIT] & instr_i[OPSEL_BIT];
        dec_o.alu     = alu_ctrl_t'(instr_i[CTRL_HI:CTRL_LO]);
        dec_o.ld_a    = ~instr_i[KIND_BIT] | instr_i[DST_A_BIT];
        dec_o.ld_d    = instr_i[KIND_BIT] & instr_i[DST_D_BIT];
        dec_o.wr_m    = instr_i[KIND_BIT] & instr_i[DST_M_BIT];
        dec_o.jmp     = instr_i[KIND_BIT] ? instr_i[JMP_W-1:0] : '0;
    end
endmodule

// File: rtl/acc_cpu16_branch.sv
// Module: jump decision from the requested conditions and ALU flags.
// Assumes the request mask is already zero for non-compute instructions.
module acc_cpu16_branch
    import acc_cpu16_pkg::*;
(
    input  logic [JMP_W-1:0] jmp_i,
    input  logic             zr_i,
    input  logic             ng_i,
    output logic             take_o
);
    logic pos;

    // Any requested condition (neg, zero, pos) that matches takes the jump
    always_comb begin
        pos    = ~zr_i & ~ng_i;
        take_o = (jmp_i[2] & ng_i) | (jmp_i[1] & zr_i) | (jmp_i[0] & pos);
    end
endmodule

// File: rtl/acc_cpu16_reg.sv
// Module: load-enabled register with synchronous active-low clear.
// Assumes clear has priority over load.
module acc_cpu16_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Clear on reset, else capture when loaded
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (ld_i) q_o <= d_i;
    end
endmodule

// File: rtl/acc_cpu16_pc.sv
// Module: program counter.
// Assumes priority reset > load > increment; increment wraps at 2^PC_W.
module acc_cpu16_pc #(
    parameter int PC_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_i,
    input  logic [PC_W-1:0] ld_val_i,
    output logic [PC_W-1:0] pc_o
);
    // Next-instruction address selection
    always_ff @(posedge clk) begin
        if (!rst_n)    pc_o <= '0;
        else if (ld_i) pc_o <= ld_val_i;
        else           pc_o <= pc_o + 1'b1;
    end

    // R10
    pc_reset_chk: assert property (@(posedge clk) !rst_n |=> pc_o == '0);
    // R10
    pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> pc_o == $past(ld_val_i));
    // R10
    pc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> pc_o == $past(pc_o) + 1'b1);
endmodule

// File: rtl/acc_cpu16.sv
// Module: single-cycle accumulator processor core (top).
// Assumes separate program and data memories with same-cycle read data;
// A, D and PC update on the rising edge, all outputs are combinational
// from the current instruction and register state.
module acc_cpu16
    import acc_cpu16_pkg::*;
#(
    parameter int PC_W   = 15,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] dmem_rdata_i,
    output logic [ADDR_W-1:0] dmem_addr_o,
    output logic [WORD_W-1:0] dmem_wdata_o,
    output logic              dmem_we_o,
    output logic [PC_W-1:0]   pc_o
);
    dec_t              dec;
    logic [WORD_W-1:0] a_q, d_q, a_next, y_op, alu_res;
    logic              zr, ng, pc_load;

    acc_cpu16_decode u_dec (.instr_i(instr_i), .dec_o(dec));

    // Second operand and A-input source selection
    always_comb begin
        y_op   = dec.sel_mem ? dmem_rdata_i : a_q;
        a_next = dec.is_comp ? alu_res : {1'b0, instr_i[LIT_W-1:0]};
    end

    acc_cpu16_alu #(.W(WORD_W)) u_alu (
        .x_i(d_q), .y_i(y_op), .ctrl_i(dec.alu),
        .res_o(alu_res), .zr_o(zr), .ng_o(ng)
    );

    acc_cpu16_branch u_br (
        .jmp_i(dec.jmp), .zr_i(zr), .ng_i(ng), .take_o(pc_load)
    );

    acc_cpu16_reg #(.W(WORD_W)) u_areg (
        .clk(clk), .rst_n(rst_n), .ld_i(dec.ld_a), .d_i(a_next), .q_o(a_q)
    );
    acc_cpu16_reg #(.W(WORD_W)) u_dreg (
        .clk(clk), .rst_n(rst_n), .ld_i(dec.ld_d), .d_i(alu_res), .q_o(d_q)
    );

    acc_cpu16_pc #(.PC_W(PC_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .ld_i(pc_load),
        .ld_val_i(a_q[PC_W-1:0]), .pc_o(pc_o)
    );

    // Data-memory side outputs
    always_comb begin
        dmem_addr_o  = a_q[ADDR_W-1:0];
        dmem_wdata_o = alu_res;
        dmem_we_o    = dec.wr_m;
    end

    // R2
    lit_keeps_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_i[KIND_BIT] |=> d_q == $past(d_q));
    // R2
    lit_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_i[KIND_BIT] |-> !pc_load);
    // R7
    lit_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_i[KIND_BIT] |-> !dmem_we_o);
    // R8
    lit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_i[KIND_BIT] |=> dmem_addr_o == $past(instr_i[ADDR_W-1:0]));
    // R3
    comp_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[KIND_BIT] && instr_i[DST_A_BIT])
        |=> dmem_addr_o == $past(dmem_wdata_o[ADDR_W-1:0]));
    // R6
    comp_d_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[KIND_BIT] && instr_i[DST_D_BIT]) |=> d_q == $past(dmem_wdata_o));
endmodule

// File: tb/acc_cpu16_tb_top.sv
// Scoreboard bench: the driver pushes per-cycle expectations computed by a
// behavioural model of the requirements; the monitor pops and compares.
module acc_cpu16_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_i = 16'h0000;
    logic [15:0] dmem_rdata_i = 16'h0000;
    logic [14:0] dmem_addr_o;
    logic [15:0] dmem_wdata_o;
    logic        dmem_we_o;
    logic [14:0] pc_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [14:0] pc;
        logic [14:0] addr;
        logic        we;
        logic [15:0] wdata;
        string       req;
    } exp_t;
    exp_t sb[$];

    logic [15:0] m_a = '0, m_d = '0;
    logic [14:0] m_pc = '0;

    // Comp codes (bits 11..6)
    localparam logic [5:0] C_ZERO = 6'b101010, C_ONE = 6'b111111,
        C_NEG1 = 6'b111010, C_D = 6'b001100, C_A = 6'b110000,
        C_NOTD = 6'b001101, C_NEGD = 6'b001111, C_DP1 = 6'b011111,
        C_AP1 = 6'b110111, C_DM1 = 6'b001110, C_DPA = 6'b000010,
        C_DMA = 6'b010011, C_AMD = 6'b000111, C_DANDA = 6'b000000,
        C_DORA = 6'b010101;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu16 dut_i (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .dmem_rdata_i(dmem_rdata_i),
        .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o),
        .dmem_we_o(dmem_we_o), .pc_o(pc_o)
    );

    function automatic logic [15:0] ci(input logic a, input logic [5:0] c,
                                       input logic [2:0] dst, input logic [2:0] j);
        return {3'b111, a, c, dst, j};
    endfunction

    function automatic logic [15:0] model_alu(input logic [15:0] x, input logic [15:0] y,
                                              input logic [5:0] c);
        logic [15:0] r;
        if (c[5]) x = '0;
        if (c[4]) x = ~x;
        if (c[3]) y = '0;
        if (c[2]) y = ~y;
        r = c[1] ? x + y : x & y;
        return c[0] ? ~r : r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: apply one instruction, queue its expectations, advance model
    task automatic step(input logic [15:0] ins, input logic [15:0] din, input string req);
        exp_t e;
        logic [15:0] r;
        logic jmp;
        @(posedge clk); #1;
        rst_n = 1'b1;
        instr_i = ins;
        dmem_rdata_i = din;
        e.pc = m_pc; e.addr = m_a[14:0]; e.req = req;
        if (!ins[15]) begin
            e.we = 1'b0; e.wdata = '0;
            m_a = {1'b0, ins[14:0]};
            m_pc = m_pc + 1'b1;
        end else begin
            r = model_alu(m_d, ins[12] ? din : m_a, ins[11:6]);
            e.we = ins[3]; e.wdata = r;
            jmp = (ins[2] && r[15]) || (ins[1] && r == 0) || (ins[0] && r != 0 && !r[15]);
            m_pc = jmp ? m_a[14:0] : m_pc + 1'b1;
            if (ins[5]) m_a = r;
            if (ins[4]) m_d = r;
        end
        sb.push_back(e);
    endtask

    task automatic do_reset(input int n, input logic [15:0] ins);
        @(posedge clk); #1;
        rst_n = 1'b0;
        instr_i = ins;
        repeat (n - 1) @(posedge clk);
        m_a = '0; m_d = '0; m_pc = '0;
    endtask

    // Monitor: compare outputs mid-cycle against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "pc", {1'b0, pc_o}, {1'b0, e.pc});
                check(e.req, "addr", {1'b0, dmem_addr_o}, {1'b0, e.addr});
                check(e.req, "we", {15'd0, dmem_we_o}, {15'd0, e.we});
                if (e.we) check(e.req, "wdata", dmem_wdata_o, e.wdata);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset(3, 16'h0000);
        // R1: D, A and PC are zero after reset
        step(ci(0, C_D, 3'b001, 3'b000), 16'h0, "R1");
        // R2, R6: literal then D=A, then M=D shows D
        step(16'h1234, 16'h0, "R2");
        step(ci(0, C_A, 3'b010, 3'b000), 16'h0, "R6");
        step(ci(0, C_D, 3'b001, 3'b000), 16'h0, "R6");
        // R2: literal with destination-like low bits must not touch D or write
        step(16'h003F, 16'h0, "R2");
        step(ci(0, C_D, 3'b001, 3'b000), 16'h0, "R2");
        // R8: address follows A
        step(16'h7FFF, 16'h0, "R8");
        step(16'h0A5C, 16'h0, "R8");
        // R5: each ALU function through the memory destination
        begin
            logic [5:0] fns [13] = '{C_ZERO, C_ONE, C_NEG1, C_A, C_NOTD, C_NEGD,
                C_DP1, C_AP1, C_DM1, C_DPA, C_DMA, C_AMD, C_DANDA};
            foreach (fns[i]) step(ci(0, fns[i], 3'b001, 3'b000), 16'h0, "R5");
        end
        step(ci(0, C_DORA, 3'b001, 3'b000), 16'h0, "R5");
        // R4: second operand from memory input
        step(ci(1, C_DPA, 3'b001, 3'b000), 16'h0F0F, "R4");
        step(ci(1, C_A, 3'b001, 3'b000), 16'hBEEF, "R4");
        step(ci(0, C_A, 3'b001, 3'b000), 16'hBEEF, "R4");
        // R3: A loaded from the ALU, then visible on the address
        step(ci(0, C_DP1, 3'b100, 3'b000), 16'h0, "R3");
        step(ci(0, C_NEG1, 3'b100, 3'b000), 16'h0, "R3");
        step(ci(0, C_ZERO, 3'b000, 3'b000), 16'h0, "R3");
        // R6: all three destinations at once
        step(ci(0, C_DM1, 3'b111, 3'b000), 16'h0, "R6");
        step(ci(0, C_D, 3'b001, 3'b000), 16'h0, "R6");
        // R9: every jump code against negative, zero and positive results
        for (int j = 0; j < 8; j++) begin
            for (int k = 0; k < 3; k++) begin
                logic [5:0] c;
                c = (k == 0) ? C_NEG1 : (k == 1) ? C_ZERO : C_ONE;
                step(16'h0100 + 16'(j * 4 + k), 16'h0, "R9");
                step(ci(0, c, 3'b000, 3'(j)), 16'h0, "R9");
            end
        end
        // R10: jump to the top address, then wrap to zero
        step(16'h7FFF, 16'h0, "R10");
        step(ci(0, C_ZERO, 3'b000, 3'b111), 16'h0, "R10");
        step(16'h0000, 16'h0, "R10");
        step(16'h0001, 16'h0, "R10");
        // R1, R10: set D nonzero, then reset over an unconditional jump
        step(ci(0, C_ONE, 3'b010, 3'b000), 16'h0, "R1");
        step(16'h0200, 16'h0, "R1");
        do_reset(2, ci(0, C_ZERO, 3'b000, 3'b111));
        step(ci(0, C_D, 3'b001, 3'b000), 16'h0, "R1");
        step(16'h0000, 16'h0, "R10");
        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule